// File: doc/BRIEF.md
# Single-Page Byte Update Buffer for a Small Emulated EEPROM

The block holds a small byte-addressable non-volatile store, modelled as a register array split into 16-byte pages, together with the write buffer and the sequencer that update it. Software first picks an operation by writing a control word, either a page update or a full erase. For a page update it then posts between one and sixteen address/data pairs, in any order, through a byte write port. Setting the start bit commits the whole set of bytes in one step.

The commit takes `COMMIT_CYCLES` clock cycles, and the busy flag is high for that whole window. During the window the array reads as erased and the block ignores any attempt to write or to cancel. When the commit finishes, the start bit and the selected operation bit clear themselves and the write buffer is emptied. A sticky error flag records any byte that falls outside the page of the first buffered byte.

The control word is a 4-bit write, `ctl_wdata`. Bit 0 selects the full erase, bit 1 selects the page update, bit 2 is start, and bit 3 clears the error flag.

Top module: `eep_page_buf`

## Requirements
- R1: After reset every byte reads back as FFh, and the start, page, erase, busy and error outputs are all 0.
- R2: When the page update bit (control bit 1) is set, the buffer accepts up to 16 byte writes in any order within one page. Setting start (control bit 2) writes each buffered byte to the array with its full new value, so a bit can change from 1 to 0 or from 0 to 1.
- R3: A page update leaves unchanged every byte that was not buffered, both in the same page and in other pages.
- R4: If software buffers the same address more than once before start, only the last data written reaches the array.
- R5: A buffered write whose upper address bits differ from those of the first buffered byte is dropped and sets the sticky error flag. The flag is cleared only by a control write with bit 3 set while the block is idle, and it stays set across commits.
- R6: On the clock edge that ends an operation, the start, page and erase outputs return to 0 and the buffer is emptied.
- R7: A start with the erase bit (control bit 0) set writes FFh to every location. When both operation bits are set, the erase wins and any buffered bytes are discarded.
- R8: While busy, every control write is ignored. In particular, clearing the start bit neither stops nor shortens the running operation, and start stays at 1.
- R9: Busy goes high on the edge that accepts an effective start and stays high for exactly `COMMIT_CYCLES` cycles. The array shows its new contents on the edge at which busy falls.
- R10: While busy, the read port returns FFh and byte writes are ignored.
- R11: Two stimuli have no effect on the array or on busy: a start with no operation bit set or with a page update whose buffer is empty, and byte writes made while the page update bit is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 4 | Control word: bit0 erase, bit1 page update, bit2 start, bit3 clear error |
| stat_start | output | 1 | Start bit, held until the operation ends |
| stat_page | output | 1 | Page update selected |
| stat_erase | output | 1 | Full erase selected |
| stat_busy | output | 1 | Commit in progress |
| stat_err | output | 1 | Sticky out-of-page write error |
| mem_wr | input | 1 | Byte write strobe into the buffer |
| mem_waddr | input | ADDR_W | Byte write address |
| mem_wdata | input | DATA_W | Byte write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, combinational; FFh while busy |

## Verification
The assertions assume that software issues a start only when an operation is actually selected, and that busy can begin only from a control write that carries the start bit. They also assume that no control write arriving while busy reaches the sequencer state. For the sticky error check, a control write with bit 3 set is the only event that may lower the flag. The stimulus follows the same pattern throughout: select, buffer, start, then wait for busy to fall. Ignored writes and cancellation attempts are injected only inside a known busy window, and every read of the array is taken at an idle point, where the bench model is exact.

// File: rtl/eep_pkg.sv
// Package: shared control-word bit positions for the page update buffer.
// Assumes a 4-bit control word; positions are fixed by the software contract.
package eep_pkg;
    localparam int CTL_ERASE  = 0;
    localparam int CTL_PAGE   = 1;
    localparam int CTL_START  = 2;
    localparam int CTL_CLRERR = 3;
    localparam int CTL_W      = 4;
endpackage

// File: rtl/eep_wbuf.sv
// Write buffer: collects byte writes for one page, tagged by the first
// address entered. Later writes to a slot overwrite earlier ones. Writes to
// another page are dropped and raise a sticky error.
// Assumes wr_en is already gated so it is low while a commit is running.
module eep_wbuf #(
    parameter int DATA_W = 8,
    parameter int PB     = 4,
    parameter int TAG_W  = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [TAG_W+PB-1:0]               wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic                              clr_buf,
    input  logic                              clr_err,
    output logic [(1<<PB)-1:0]                valid_o,
    output logic [(1<<PB)-1:0][DATA_W-1:0]    data_o,
    output logic [TAG_W-1:0]                  tag_o,
    output logic                              any_o,
    output logic                              err_o
);
    localparam int SLOTS = 1 << PB;

    logic [SLOTS-1:0]              valid_q;
    logic [SLOTS-1:0][DATA_W-1:0]  data_q;
    logic [TAG_W-1:0]              tag_q;
    logic                          err_q;
    logic [TAG_W-1:0]              wr_tag;
    logic [PB-1:0]                 wr_slot;
    logic                          accept;
    logic                          reject;

    // Split the address and decide whether this write may join the buffer.
    always_comb begin
        wr_tag  = wr_addr[TAG_W+PB-1:PB];
        wr_slot = wr_addr[PB-1:0];
        accept  = wr_en && (!any_o || (wr_tag == tag_q));
        reject  = wr_en && any_o && (wr_tag != tag_q);
    end

    assign any_o   = |valid_q;
    assign valid_o = valid_q;
    assign data_o  = data_q;
    assign tag_o   = tag_q;
    assign err_o   = err_q;

    // Per-slot valid bit and data byte, one register set per slot.
    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid_q[s] <= 1'b0;
                    data_q[s]  <= '0;
                end else if (clr_buf) begin
                    valid_q[s] <= 1'b0;
                end else if (accept && (wr_slot == PB'(s))) begin
                    valid_q[s] <= 1'b1;
                    data_q[s]  <= wr_data;
                end
            end
        end
    endgenerate

    // Page tag is captured by the first accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tag_q <= '0;
        else if (accept && !any_o)
            tag_q <= wr_tag;
    end

    // Sticky error: a reject sets it, an explicit clear lowers it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (reject)
            err_q <= 1'b1;
        else if (clr_err)
            err_q <= 1'b0;
    end
endmodule

// File: rtl/eep_seq.sv
// Sequencer: holds the control bits, starts an operation when start is set
// with something to do, and times the commit with a down-counter. Ignores
// control writes while busy, so software cannot cancel an operation.
// Assumes COMMIT_CYCLES >= 1.
module eep_seq
    import eep_pkg::*;
#(
    parameter int COMMIT_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              buf_any,
    output logic              start_o,
    output logic              page_o,
    output logic              erase_o,
    output logic              busy_o,
    output logic              commit_o,
    output logic              commit_erase_o,
    output logic              clr_err_o
);
    localparam int CNT_W = $clog2(COMMIT_CYCLES + 1);

    logic              start_q, page_q, erase_q, busy_q, op_erase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              ctl_take;
    logic              go;

    // Decode an accepted control write and whether it launches an operation.
    always_comb begin
        ctl_take  = ctl_wr && !busy_q;
        go        = ctl_take && ctl_wdata[CTL_START] &&
                    (ctl_wdata[CTL_ERASE] || (ctl_wdata[CTL_PAGE] && buf_any));
        commit_o  = busy_q && (cnt_q == '0);
        clr_err_o = ctl_take && ctl_wdata[CTL_CLRERR];
    end

    // Control bits, busy flag and commit timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q    <= 1'b0;
            page_q     <= 1'b0;
            erase_q    <= 1'b0;
            busy_q     <= 1'b0;
            op_erase_q <= 1'b0;
            cnt_q      <= '0;
        end else if (commit_o) begin
            start_q <= 1'b0;
            page_q  <= 1'b0;
            erase_q <= 1'b0;
            busy_q  <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end else if (ctl_take) begin
            page_q     <= ctl_wdata[CTL_PAGE];
            erase_q    <= ctl_wdata[CTL_ERASE];
            start_q    <= go;
            busy_q     <= go;
            op_erase_q <= ctl_wdata[CTL_ERASE];
            cnt_q      <= CNT_W'(COMMIT_CYCLES - 1);
        end
    end

    assign start_o        = start_q;
    assign page_o         = page_q;
    assign erase_o        = erase_q;
    assign busy_o         = busy_q;
    assign commit_erase_o = op_erase_q;
endmodule

// File: rtl/eep_store.sv
// Storage array: one byte register per location, reset to the erased value.
// On a commit pulse it either erases everything or loads the valid buffer
// slots of the tagged page. Reads are combinational and show all ones while
// busy. Assumes commit is a single-cycle pulse.
module eep_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6,
    parameter int PB     = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              commit,
    input  logic                              commit_erase,
    input  logic [ADDR_W-PB-1:0]              tag,
    input  logic [(1<<PB)-1:0]                valid,
    input  logic [(1<<PB)-1:0][DATA_W-1:0]    data,
    input  logic                              busy,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic [DATA_W-1:0]                 rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int SLOTS = 1 << PB;
    localparam int TAG_W = ADDR_W - PB;

    logic [DEPTH-1:0][DATA_W-1:0] mem_q;

    // One register per location, updated from its own buffer slot.
    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_loc
            localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(i / SLOTS);
            localparam int MY_SLOT = i % SLOTS;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem_q[i] <= '1;
                else if (commit && commit_erase)
                    mem_q[i] <= '1;
                else if (commit && (tag == MY_TAG) && valid[MY_SLOT])
                    mem_q[i] <= data[MY_SLOT];
            end
        end
    endgenerate

    // Read mux, masked to the erased value during a commit.
    always_comb begin
        rd_data = busy ? '1 : mem_q[rd_addr];
    end
endmodule

// File: rtl/eep_page_buf.sv
// Top: page update buffer for a small emulated EEPROM. Wires together the
// sequencer, the write buffer and the storage array. Byte writes reach the
// buffer only while page update is selected and no commit runs.
// Assumes ADDR_W > PB.
module eep_page_buf
    import eep_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int ADDR_W        = 6,
    parameter int PB            = 4,
    parameter int COMMIT_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic              stat_start,
    output logic              stat_page,
    output logic              stat_erase,
    output logic              stat_busy,
    output logic              stat_err,
    input  logic              mem_wr,
    input  logic [ADDR_W-1:0] mem_waddr,
    input  logic [DATA_W-1:0] mem_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int TAG_W = ADDR_W - PB;
    localparam int SLOTS = 1 << PB;

    logic                          buf_any, commit, commit_erase, clr_err;
    logic                          buf_wr;
    logic [SLOTS-1:0]              buf_valid;
    logic [SLOTS-1:0][DATA_W-1:0]  buf_data;
    logic [TAG_W-1:0]              buf_tag;

    // Gate byte writes: only with page update selected and while idle.
    assign buf_wr = mem_wr && stat_page && !stat_busy;

    eep_seq #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .buf_any(buf_any),
        .start_o(stat_start), .page_o(stat_page), .erase_o(stat_erase),
        .busy_o(stat_busy), .commit_o(commit),
        .commit_erase_o(commit_erase), .clr_err_o(clr_err)
    );

    eep_wbuf #(.DATA_W(DATA_W), .PB(PB), .TAG_W(TAG_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(buf_wr), .wr_addr(mem_waddr), .wr_data(mem_wdata),
        .clr_buf(commit), .clr_err(clr_err),
        .valid_o(buf_valid), .data_o(buf_data), .tag_o(buf_tag),
        .any_o(buf_any), .err_o(stat_err)
    );

    eep_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PB(PB)) u_store (
        .clk(clk), .rst_n(rst_n),
        .commit(commit), .commit_erase(commit_erase),
        .tag(buf_tag), .valid(buf_valid), .data(buf_data),
        .busy(stat_busy), .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: rtl/eep_page_buf_chk.sv
// Checker: temporal properties of the page update buffer, seen at its ports.
// Bound to every instance of eep_page_buf.
module eep_page_buf_chk
    import eep_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int COMMIT_CYCLES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_wr,
    input logic [CTL_W-1:0]  ctl_wdata,
    input logic              stat_start,
    input logic              stat_page,
    input logic              stat_erase,
    input logic              stat_busy,
    input logic              stat_err,
    input logic [DATA_W-1:0] rd_data
);
    logic [31:0] run_q;

    // Length of the current busy window, in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else if (stat_busy)
            run_q <= run_q + 1;
        else
            run_q <= '0;
    end

    // R8
    busy_holds_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_busy |-> stat_start);

    // R6
    op_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_busy) |-> (!stat_start && !stat_page && !stat_erase));

    // R9
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_busy) |-> (run_q == COMMIT_CYCLES));

    // R9
    busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_busy) |-> ($past(ctl_wr) && $past(ctl_wdata[CTL_START])));

    // R10
    busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_busy |-> (rd_data == '1));

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stat_err) && !($past(ctl_wr) && $past(ctl_wdata[CTL_CLRERR])))
            |-> stat_err);
endmodule

bind eep_page_buf eep_page_buf_chk #(
    .DATA_W(DATA_W), .COMMIT_CYCLES(COMMIT_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .stat_start(stat_start), .stat_page(stat_page), .stat_erase(stat_erase),
    .stat_busy(stat_busy), .stat_err(stat_err), .rd_data(rd_data)
);

// File: tb/eep_page_buf_tb.sv
// Bench: sweeps every page and every location of a 64-byte configuration
// against an arithmetic model of the array.
module eep_page_buf_tb;
    localparam int PERIOD = 10;
    localparam int DW     = 8;
    localparam int AW     = 6;
    localparam int PB     = 4;
    localparam int CC     = 8;
    localparam int DEPTH  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_wr = 1'b0;
    logic [3:0]    ctl_wdata = '0;
    logic          stat_start, stat_page, stat_erase, stat_busy, stat_err;
    logic          mem_wr = 1'b0;
    logic [AW-1:0] mem_waddr = '0;
    logic [DW-1:0] mem_wdata = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] exp_mem [DEPTH];

    eep_page_buf #(.DATA_W(DW), .ADDR_W(AW), .PB(PB), .COMMIT_CYCLES(CC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .stat_start(stat_start), .stat_page(stat_page), .stat_erase(stat_erase),
        .stat_busy(stat_busy), .stat_err(stat_err),
        .mem_wr(mem_wr), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic ctl(input logic [3:0] w);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = w;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic bwr(input int a, input int d);
        @(negedge clk); mem_wr = 1'b1; mem_waddr = AW'(a); mem_wdata = DW'(d);
        @(negedge clk); mem_wr = 1'b0;
    endtask

    // Issue a control word with start and follow the busy window.
    task automatic start_run(input logic [3:0] w, input bit meddle, output int n);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = w;
        n = 0;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk); ctl_wr = 1'b0; mem_wr = 1'b0;
            if (!stat_busy) break;
            n++;
            if (meddle) begin
                rd_addr = AW'(n * 5); #1;
                chk(rd_data == 8'hFF, "R10 read while busy", rd_data, 8'hFF);
                if (n == 2) begin mem_wr = 1'b1; mem_waddr = 6'h12; mem_wdata = 8'hEE; end
                if (n == 3) begin ctl_wr = 1'b1; ctl_wdata = 4'b0000; end
                if (n == 5) chk(stat_start == 1'b1, "R8 start held", stat_start, 1);
            end
        end
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = AW'(a); #1;
            chk(rd_data == exp_mem[a], req, rd_data, exp_mem[a]);
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({stat_start, stat_page, stat_erase, stat_busy, stat_err} == 5'b0,
            "R1 status after reset", {stat_start, stat_page, stat_erase, stat_busy, stat_err}, 0);
        sweep("R1 erased after reset");

        // R2: fill every page in a scrambled order, then commit.
        for (int p = 0; p < DEPTH / 16; p++) begin
            ctl(4'b0010);
            for (int i = 0; i < 16; i++) begin
                int a = p * 16 + ((i * 7 + 3) % 16);
                bwr(a, (a * 37 + 11) & 8'hFF);
                exp_mem[a] = DW'((a * 37 + 11) & 8'hFF);
            end
            start_run(4'b0110, 1'b0, n);
            chk(n == CC, "R9 busy length", n, CC);
            chk({stat_start, stat_page, stat_erase} == 3'b0, "R6 bits cleared",
                {stat_start, stat_page, stat_erase}, 0);
            sweep("R2 page fill");
        end

        // R3/R4: partial update with both bit directions and a duplicate.
        ctl(4'b0010);
        bwr(6'h23, ~exp_mem[6'h23]); exp_mem[6'h23] = ~exp_mem[6'h23];
        bwr(6'h29, 8'h11);
        bwr(6'h29, 8'hC3); exp_mem[6'h29] = 8'hC3;
        start_run(4'b0110, 1'b0, n);
        sweep("R3 R4 partial update");

        // R5: out-of-page write dropped, error sticky across commit.
        ctl(4'b0010);
        bwr(6'h05, 8'h77); exp_mem[6'h05] = 8'h77;
        bwr(6'h25, 8'h99);
        chk(stat_err == 1'b1, "R5 error set", stat_err, 1);
        bwr(6'h0A, 8'h88); exp_mem[6'h0A] = 8'h88;
        start_run(4'b0110, 1'b0, n);
        sweep("R5 rejected byte absent");
        chk(stat_err == 1'b1, "R5 error sticky", stat_err, 1);
        ctl(4'b1000);
        chk(stat_err == 1'b0, "R5 error cleared", stat_err, 0);

        // R8/R10: interference while busy.
        ctl(4'b0010);
        bwr(6'h14, 8'h3C); exp_mem[6'h14] = 8'h3C;
        start_run(4'b0110, 1'b1, n);
        chk(n == CC, "R8 busy not shortened", n, CC);
        sweep("R10 busy write ignored");

        // R11: start with an empty buffer, and writes without page select.
        ctl(4'b0110);
        chk(stat_busy == 1'b0, "R11 empty start ignored", stat_busy, 0);
        chk(stat_start == 1'b0, "R11 start dropped", stat_start, 0);
        ctl(4'b0000);
        bwr(6'h11, 8'h00);
        ctl(4'b0110);
        chk(stat_busy == 1'b0, "R11 unselected write ignored", stat_busy, 0);
        ctl(4'b0000);
        sweep("R11 array unchanged");

        // R7: erase wins over a buffered page update.
        ctl(4'b0010);
        bwr(6'h03, 8'h00);
        start_run(4'b0111, 1'b0, n);
        for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'hFF;
        chk(n == CC, "R7 erase busy length", n, CC);
        sweep("R7 chip erase");
        chk({stat_start, stat_page, stat_erase} == 3'b0, "R6 bits cleared after erase",
            {stat_start, stat_page, stat_erase}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule